// File: doc/BRIEF.md
# MII Transmit Release Controller

This block sits between a downstream output buffer and the transmit side of a 4-bit MII-style Ethernet PHY interface. An upstream packet filter tells it, through a one-cycle strobe, the byte length of each packet it has accepted into the buffer. The block adds each length to a running total of the bytes waiting in the buffer. While that total is nonzero it drains the buffer one nibble per clock: it raises the buffer read enable and the transmit enable together and passes the buffer's nibble onto the transmit data bus. Each byte occupies two nibble cycles. The total drops by one after the second nibble of every byte.

A small state machine controls the drain. It has three states. `ST_WAIT` is the idle state. `ST_LO` is the cycle carrying a byte's low nibble. `ST_HI` is the cycle carrying its high nibble, and the byte is retired in that cycle. The transitions are:

- `ST_WAIT -> ST_LO` when the registered pending count is nonzero. Otherwise the machine stays in `ST_WAIT`.
- `ST_LO -> ST_HI` always.
- `ST_HI -> ST_LO` when the count still holds bytes after this retire and after any length that arrives in the same cycle.
- `ST_HI -> ST_WAIT` when it does not.

Lengths that arrive during a drain extend it without a gap. The buffer is expected to present the nibble at its head combinationally, so that the nibble is valid in the same cycle as its read enable.

Top module: `mii_tx_release`

## Requirements
- R1: A synchronous active-high `rst` clears the pending count and the state. `tx_en` and `buf_rd` are 0 and `txd` is 4'h0 from the first edge with `rst` high. After reset, no bytes that were pending before it are sent.
- R2: When `len_vld` is sampled high with a nonzero `len_bytes` at edge k while idle with no bytes pending, `tx_en` is first high after edge k+1.
- R3: Starting from idle, a total of N pending bytes produces exactly 2*N consecutive cycles with `tx_en` high. `tx_en` is low again in the cycle after the last nibble.
- R4: `buf_rd` equals `tx_en` in every cycle.
- R5: `txd` equals `buf_nib` while `tx_en` is 1 and is 4'h0 while `tx_en` is 0.
- R6: A length that arrives while a drain is in progress is added to the pending total. The burst lengthens by twice that length with no idle cycle in it.
- R7: A length that arrives in the same cycle in which the last pending byte is retired is not lost. The burst continues into the new bytes without a gap.
- R8: A `len_vld` strobe carrying a length of 0 has no effect. It starts no transmission and does not change the length of a running burst.
- R9: Strobes in consecutive cycles accumulate. Their lengths are summed into one burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock, one nibble per cycle |
| rst | input | 1 | Synchronous active-high reset |
| len_vld | input | 1 | One-cycle strobe: an accepted packet's length is on `len_bytes` |
| len_bytes | input | LEN_W | Byte length of the accepted packet |
| buf_nib | input | 4 | Nibble at the head of the output buffer |
| tx_en | output | 1 | Transmit enable toward the PHY |
| txd | output | 4 | Transmit data nibble toward the PHY |
| buf_rd | output | 1 | Read enable (pop) for the output buffer |

## Verification
The drain is tried with several two-strobe patterns, each a pair of a first length, a delay and a second length:

- Strobes in consecutive cycles show that the lengths are accumulated rather than overwritten.
- A second strobe in the middle of the drain shows that a running burst is extended.
- A second strobe landing exactly on the last retire cycle separates a correct simultaneous add-and-decrement from one that drops an update or inserts a gap.
- A strobe one cycle later than that must give two separate bursts. This pins down the idle-path start latency.
- A zero-length second strobe shows that empty lengths are ignored.

For every pattern the bench checks the latency to the first enable, the total enable cycles, the number of bursts, and the per-cycle agreement of read enable and data with the enable. Directed tests then cover reset in the middle of a burst and a lone zero-length strobe.

// File: rtl/mii_txr_pkg.sv
package mii_txr_pkg;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2
    } txr_state_e;

    localparam int NIB_W = 4;

endpackage

// File: rtl/txr_pend_acc.sv
module txr_pend_acc #(
    parameter int LEN_W = 16,
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             add_vld,
    input  logic [LEN_W-1:0] add_len,
    input  logic             dec,
    output logic             cnt_nz,
    output logic             nxt_nz
);
    localparam int SUM_W = CNT_W + 1;
    localparam int PAD_W = SUM_W - LEN_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [SUM_W-1:0] add_ext;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] nxt;

    // Add and retire in the same cycle so that no update is lost.
    always_comb begin
        add_ext = add_vld ? {{PAD_W{1'b0}}, add_len} : '0;
        sum     = {1'b0, cnt_q} + add_ext;
        nxt     = sum - {{CNT_W{1'b0}}, dec};
        cnt_d   = nxt[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt_nz = |cnt_q;
    assign nxt_nz = |cnt_d;

    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        dec |-> cnt_nz);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        sum[CNT_W] == 1'b0);

endmodule

// File: rtl/txr_nib_fsm.sv
module txr_nib_fsm
    import mii_txr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cnt_nz,
    input  logic nxt_nz,
    output logic xmit,
    output logic dec
);
    txr_state_e state_q;
    txr_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_WAIT;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: state_d = cnt_nz ? ST_LO : ST_WAIT;
            ST_LO:   state_d = ST_HI;
            ST_HI:   state_d = nxt_nz ? ST_LO : ST_WAIT;
            default: state_d = ST_WAIT;
        endcase
    end

    always_comb begin
        xmit = 1'b0;
        dec  = 1'b0;
        unique case (state_q)
            ST_WAIT: begin
                xmit = 1'b0;
                dec  = 1'b0;
            end
            ST_LO: begin
                xmit = 1'b1;
                dec  = 1'b0;
            end
            ST_HI: begin
                xmit = 1'b1;
                dec  = 1'b1;
            end
            default: begin
                xmit = 1'b0;
                dec  = 1'b0;
            end
        endcase
    end

    // R3
    lo_then_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LO) |=> (state_q == ST_HI));

    // R2
    rise_needs_count_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(xmit) |-> $past(cnt_nz));

    // R3
    active_has_bytes_chk: assert property (@(posedge clk) disable iff (rst)
        xmit |-> cnt_nz);

endmodule

// File: rtl/txr_out_stage.sv
module txr_out_stage
    import mii_txr_pkg::*;
(
    input  logic             xmit,
    input  logic [NIB_W-1:0] buf_nib,
    output logic             tx_en,
    output logic             buf_rd,
    output logic [NIB_W-1:0] txd
);
    // The enable and the pop come from one state bit, so they cannot diverge.
    always_comb begin
        tx_en  = xmit;
        buf_rd = xmit;
        txd    = xmit ? buf_nib : '0;
    end

endmodule

// File: rtl/mii_tx_release.sv
module mii_tx_release
    import mii_txr_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             len_vld,
    input  logic [LEN_W-1:0] len_bytes,
    input  logic [3:0]       buf_nib,
    output logic             tx_en,
    output logic [3:0]       txd,
    output logic             buf_rd
);
    logic cnt_nz;
    logic nxt_nz;
    logic xmit;
    logic dec;

    txr_pend_acc #(
        .LEN_W (LEN_W),
        .CNT_W (CNT_W)
    ) u_acc (
        .clk     (clk),
        .rst     (rst),
        .add_vld (len_vld),
        .add_len (len_bytes),
        .dec     (dec),
        .cnt_nz  (cnt_nz),
        .nxt_nz  (nxt_nz)
    );

    txr_nib_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .cnt_nz (cnt_nz),
        .nxt_nz (nxt_nz),
        .xmit   (xmit),
        .dec    (dec)
    );

    txr_out_stage u_out (
        .xmit    (xmit),
        .buf_nib (buf_nib),
        .tx_en   (tx_en),
        .buf_rd  (buf_rd),
        .txd     (txd)
    );

    // R5
    idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> (txd == 4'h0));

endmodule

// File: tb/mii_tx_release_bench.sv
module mii_tx_release_bench;
    localparam int LEN_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             len_vld = 1'b0;
    logic [LEN_W-1:0] len_bytes = '0;
    logic [3:0]       buf_nib = 4'h0;
    logic             tx_en;
    logic [3:0]       txd;
    logic             buf_rd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mii_tx_release #(.LEN_W(LEN_W), .CNT_W(20)) u_mii_tx_release (
        .clk       (clk),
        .rst       (rst),
        .len_vld   (len_vld),
        .len_bytes (len_bytes),
        .buf_nib   (buf_nib),
        .tx_en     (tx_en),
        .txd       (txd),
        .buf_rd    (buf_rd)
    );

    // Each row: first length, delay of the second strobe in cycles,
    // second length, expected enable cycles, expected burst count.
    localparam int NV = 6;
    localparam int VEC [NV][5] = '{
        '{1, 1, 0,  2, 1},   // R8 zero-length second strobe
        '{3, 1, 2, 10, 1},   // R9 consecutive strobes
        '{2, 3, 4, 12, 1},   // R6 mid-drain add
        '{2, 5, 1,  6, 1},   // R7 add on final retire cycle
        '{2, 6, 1,  6, 2},   // R2 strobe just after the drain ended
        '{5, 4, 3, 16, 1}    // R6 longer mid-drain add
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_vec(input int a, input int d, input int b,
                           input int exp_cyc, input int exp_bursts);
        int first_rise = -1;
        int hi_cnt = 0;
        int rises = 0;
        int rd_bad = 0;
        int txd_bad = 0;
        logic prev = 1'b0;
        int win = 2 * (a + b) + 10;
        @(negedge clk);
        len_vld   = 1'b1;
        len_bytes = LEN_W'(a);
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            len_vld   = 1'b0;
            len_bytes = '0;
            if (i + 1 == d) begin
                len_vld   = 1'b1;
                len_bytes = LEN_W'(b);
            end
            buf_nib = 4'((i * 7 + 3) & 15);
            #1;
            if (tx_en && !prev) begin
                rises++;
                if (first_rise < 0) first_rise = i;
            end
            if (tx_en) hi_cnt++;
            if (buf_rd != tx_en) rd_bad++;
            if (txd != (tx_en ? buf_nib : 4'h0)) txd_bad++;
            prev = tx_en;
        end
        check("R2 first enable after edge k+1", first_rise, 1);
        check("R3/R6/R7 enable cycles", hi_cnt, exp_cyc);
        check("R6/R7 burst count", rises, exp_bursts);
        check("R4 buf_rd matches tx_en", rd_bad, 0);
        check("R5 txd follows buffer or zero", txd_bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check("R1 tx_en in reset", int'(tx_en), 0);
        check("R1 buf_rd in reset", int'(buf_rd), 0);
        check("R1 txd in reset", int'(txd), 0);
        @(negedge clk);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
        end

        // R8 lone zero-length strobe starts nothing
        begin
            int hi = 0;
            @(negedge clk);
            len_vld = 1'b1;
            len_bytes = '0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                len_vld = 1'b0;
                #1;
                if (tx_en || buf_rd) hi++;
            end
            check("R8 zero length ignored", hi, 0);
        end

        // R1 reset in the middle of a burst drops the pending bytes
        begin
            int hi = 0;
            @(negedge clk);
            len_vld = 1'b1;
            len_bytes = LEN_W'(4);
            @(negedge clk);
            len_vld = 1'b0;
            repeat (3) @(negedge clk);
            #1;
            check("R1 burst running before reset", int'(tx_en), 1);
            rst = 1'b1;
            @(negedge clk);
            #1;
            check("R1 tx_en cleared by reset", int'(tx_en), 0);
            check("R1 buf_rd cleared by reset", int'(buf_rd), 0);
            rst = 1'b0;
            for (int i = 0; i < 15; i++) begin
                @(negedge clk);
                #1;
                if (tx_en || buf_rd) hi++;
            end
            check("R1 no resumed transmission", hi, 0);
        end

        // R3 a burst after reset still has exact length
        run_vec(7, 1, 0, 14, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule